// File: doc/BRIEF.md
# Viterbi Flush Control Sequencer

This block is the control sequencer of a Viterbi decoder or equalizer coprocessor. It starts in idle. A start request arrives with exactly one of the decode or equalize enables set. The sequencer then loads a per-block symbol countdown and accepts symbols until the countdown is used up.

At that point it flushes the trellis memory without any host action. Software can also force a flush in the middle of a block. To do so it drops both processing enables and raises the flush enable. No symbols are accepted during the flush. The sequencer first fixes the traceback start state, using one of two policies:
- a programmed end state;
- the state with the lowest path metric, found by scanning an external metric array one state per cycle.

It then strobes out the bits still held in the trellis, one per cycle for the traceback depth. It pulses a done flag and returns to idle.

The trellis RAM, the add-compare-select datapath and the BER counter sit outside the block. They follow the strobes the block drives. Every bit, whether decoded normally or flushed, raises a re-encode strobe. It raises a BER strobe one cycle later.

Top module: `viterbi_flush_seq`

## Requirements
- R1: After reset `mode` is 0 (idle), and `symReady`, `shiftValid`, `reEncStb`, `berStb` and `done` are all 0.
- R2: In idle, a `start` with exactly one of `decEn`/`eqEn` set moves `mode` to 1 (active) on the next cycle and loads the countdown from `blockLen`.
- R3: While active and not forced to flush, `symReady` is 1. A symbol is accepted when `symValid` and `symReady` are both 1. In any other mode `symReady` is 0.
- R4: When the countdown reaches zero, `mode` becomes 2 (flush) on its own. This happens at the clock edge that accepts the last symbol, or on the first active cycle when `blockLen` is 0.
- R5: While active, `flushEn`=1 with `decEn`=0 and `eqEn`=0 drops `symReady` in that cycle. The next cycle enters flush, even if symbols remain.
- R6: With `flushPolicy`=0 at flush entry, the traceback start `tbState` equals `endState`. Shifting begins the next cycle.
- R7: With `flushPolicy`=1, the block drives `metricAddr` 0,1,...,NUM_STATES-1 on successive cycles. `tbState` becomes the index of the lowest `metricData`, with the lower index winning a tie. Shifting begins after the last address.
- R8: During shifting, `shiftValid` is 1 for exactly TB_DEPTH cycles with `tbState` held stable.
- R9: `reEncStb` is 1 in every cycle where a symbol is accepted or a bit is shifted. `berStb` is `reEncStb` delayed by one cycle.
- R10: After the last shift cycle, `mode` returns to 0 and `done` is 1 for exactly one cycle.
- R11: A `start` with both `decEn` and `eqEn` set is ignored, and `mode` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block when idle |
| decEn | input | 1 | Decode enable |
| eqEn | input | 1 | Equalize enable |
| flushEn | input | 1 | Flush enable (forces flush when both processing enables are low) |
| flushPolicy | input | 1 | 0: fixed end state, 1: best metric |
| endState | input | STATE_W | Programmed traceback end state |
| blockLen | input | CNT_W | Symbols per block |
| symValid | input | 1 | Input symbol present |
| symReady | output | 1 | Symbol accepted this cycle when valid |
| metricAddr | output | STATE_W | Metric array read address |
| metricData | input | METRIC_W | Path metric at metricAddr (same cycle) |
| mode | output | 2 | 0 idle, 1 active, 2 flush |
| tbState | output | STATE_W | Chosen traceback start state |
| shiftValid | output | 1 | One trellis bit shifted out |
| reEncStb | output | 1 | Re-encode strobe |
| berStb | output | 1 | BER accumulate strobe |
| done | output | 1 | One-cycle flush-complete pulse |

## Verification
Two cases are the hardest to reach. The first is a forced flush that lands in the same cycle as a valid symbol. The second is a best-metric scan whose winner depends on the tie rule, or that sits at the very last state. The bench raises `flushEn` together with `symValid` mid-block. It loads metric arrays with a tie between two low indices, and with a unique minimum at the final address. A behavioural model checks every cycle of these runs, along with blocks of zero length and an invalid double-enable start.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ACTIVE = 2'd1,
    SEQ_SCAN   = 2'd2,
    SEQ_SHIFT  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic scanClear;
    logic scanStep;
    logic loadEnd;
  } dpCtl_t;
endpackage

// File: rtl/vfs_metric_scan.sv
module vfs_metric_scan #(
  parameter int NUM_STATES = 8,
  parameter int METRIC_W   = 8,
  localparam int STATE_W   = $clog2(NUM_STATES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  vfs_pkg::dpCtl_t     ctl,
  input  logic [STATE_W-1:0]  endState,
  input  logic [METRIC_W-1:0] metricData,
  output logic [STATE_W-1:0]  metricAddr,
  output logic                scanLast,
  output logic [STATE_W-1:0]  tbState
);
  localparam logic [STATE_W-1:0] LAST_IDX = STATE_W'(NUM_STATES - 1);

  logic [STATE_W-1:0]  scanIdx;
  logic [STATE_W-1:0]  bestIdx;
  logic [METRIC_W-1:0] bestMetric;
  logic                takeNew;

  assign metricAddr = scanIdx;
  assign scanLast   = (scanIdx == LAST_IDX);
  // strict less-than keeps the earlier (lower) index on a tie
  assign takeNew    = (scanIdx == '0) || (metricData < bestMetric);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanIdx    <= '0;
      bestIdx    <= '0;
      bestMetric <= '0;
      tbState    <= '0;
    end else begin
      if (ctl.scanClear) scanIdx <= '0;
      if (ctl.loadEnd) tbState <= endState;
      if (ctl.scanStep) begin
        if (takeNew) begin
          bestMetric <= metricData;
          bestIdx    <= scanIdx;
        end
        if (scanLast) tbState <= takeNew ? scanIdx : bestIdx;
        scanIdx <= scanIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vfs_ctrl.sv
module vfs_ctrl #(
  parameter int CNT_W    = 8,
  parameter int TB_DEPTH = 6,
  localparam int DEPTH_W = $clog2(TB_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             decEn,
  input  logic             eqEn,
  input  logic             flushEn,
  input  logic             flushPolicy,
  input  logic [CNT_W-1:0] blockLen,
  input  logic             symValid,
  input  logic             scanLast,
  output logic             symReady,
  output vfs_pkg::dpCtl_t  ctl,
  output logic [1:0]       mode,
  output logic             shiftValid,
  output logic             reEncStb,
  output logic             berStb,
  output logic             done
);
  import vfs_pkg::*;

  localparam logic [DEPTH_W-1:0] DEPTH_LOAD = DEPTH_W'(TB_DEPTH);

  seqState_t        state;
  logic [CNT_W-1:0]   symCnt;
  logic [DEPTH_W-1:0] shiftLeft;
  logic forceFlush, cfgOk, accept, lastSym, goFlush;

  assign cfgOk      = decEn ^ eqEn;
  assign forceFlush = flushEn && !decEn && !eqEn;
  assign symReady   = (state == SEQ_ACTIVE) && !forceFlush;
  assign accept     = symReady && symValid;
  assign lastSym    = accept && (symCnt == CNT_W'(1));
  assign goFlush    = (state == SEQ_ACTIVE) &&
                      (forceFlush || symCnt == '0 || lastSym);
  assign shiftValid = (state == SEQ_SHIFT);
  assign reEncStb   = accept || shiftValid;
  assign mode       = (state == SEQ_IDLE)   ? 2'd0 :
                      (state == SEQ_ACTIVE) ? 2'd1 : 2'd2;

  always_comb begin
    ctl.scanClear = goFlush && flushPolicy;
    ctl.loadEnd   = goFlush && !flushPolicy;
    ctl.scanStep  = (state == SEQ_SCAN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      symCnt    <= '0;
      shiftLeft <= '0;
      berStb    <= 1'b0;
      done      <= 1'b0;
    end else begin
      berStb <= reEncStb;
      done   <= 1'b0;
      unique case (state)
        SEQ_IDLE:
          if (start && cfgOk) begin
            state  <= SEQ_ACTIVE;
            symCnt <= blockLen;
          end
        SEQ_ACTIVE: begin
          if (accept) symCnt <= symCnt - 1'b1;
          if (goFlush) begin
            if (flushPolicy) state <= SEQ_SCAN;
            else begin
              state     <= SEQ_SHIFT;
              shiftLeft <= DEPTH_LOAD;
            end
          end
        end
        SEQ_SCAN:
          if (scanLast) begin
            state     <= SEQ_SHIFT;
            shiftLeft <= DEPTH_LOAD;
          end
        SEQ_SHIFT: begin
          shiftLeft <= shiftLeft - 1'b1;
          if (shiftLeft == DEPTH_W'(1)) begin
            state <= SEQ_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/viterbi_flush_seq.sv
module viterbi_flush_seq #(
  parameter int NUM_STATES = 8,
  parameter int METRIC_W   = 8,
  parameter int CNT_W      = 8,
  parameter int TB_DEPTH   = 6,
  localparam int STATE_W   = $clog2(NUM_STATES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                decEn,
  input  logic                eqEn,
  input  logic                flushEn,
  input  logic                flushPolicy,
  input  logic [STATE_W-1:0]  endState,
  input  logic [CNT_W-1:0]    blockLen,
  input  logic                symValid,
  output logic                symReady,
  output logic [STATE_W-1:0]  metricAddr,
  input  logic [METRIC_W-1:0] metricData,
  output logic [1:0]          mode,
  output logic [STATE_W-1:0]  tbState,
  output logic                shiftValid,
  output logic                reEncStb,
  output logic                berStb,
  output logic                done
);
  vfs_pkg::dpCtl_t ctl;
  logic scanLast;

  vfs_ctrl #(.CNT_W(CNT_W), .TB_DEPTH(TB_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .decEn(decEn), .eqEn(eqEn),
    .flushEn(flushEn), .flushPolicy(flushPolicy), .blockLen(blockLen),
    .symValid(symValid), .scanLast(scanLast), .symReady(symReady),
    .ctl(ctl), .mode(mode), .shiftValid(shiftValid), .reEncStb(reEncStb),
    .berStb(berStb), .done(done)
  );

  vfs_metric_scan #(.NUM_STATES(NUM_STATES), .METRIC_W(METRIC_W)) uScan (
    .clk(clk), .rstN(rstN), .ctl(ctl), .endState(endState),
    .metricData(metricData), .metricAddr(metricAddr), .scanLast(scanLast),
    .tbState(tbState)
  );
endmodule

// File: rtl/viterbi_flush_seq_check.sv
module viterbi_flush_seq_check #(
  parameter int STATE_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               decEn,
  input logic               eqEn,
  input logic               symReady,
  input logic [1:0]         mode,
  input logic [STATE_W-1:0] tbState,
  input logic               shiftValid,
  input logic               reEncStb,
  input logic               berStb,
  input logic               done
);
  a_r3_ready_only_active: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd1) |-> !symReady);
  a_r8_shift_in_flush: assert property (@(posedge clk) disable iff (!rstN)
    shiftValid |-> (mode == 2'd2));
  a_r8_tb_stable: assert property (@(posedge clk) disable iff (!rstN)
    (shiftValid && $past(shiftValid)) |-> $stable(tbState));
  a_r9_ber_follows: assert property (@(posedge clk) disable iff (!rstN)
    reEncStb |=> berStb);
  a_r10_done_after_shift: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (mode == 2'd0) && $past(shiftValid));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_invalid_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && start && decEn && eqEn) |=> (mode == 2'd0));
  a_r4_flush_from_active: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && $past(mode) != 2'd2) |-> ($past(mode) == 2'd1));
endmodule

bind viterbi_flush_seq viterbi_flush_seq_check #(.STATE_W(STATE_W)) uCheck (
  .clk(clk), .rstN(rstN), .start(start), .decEn(decEn), .eqEn(eqEn),
  .symReady(symReady), .mode(mode), .tbState(tbState),
  .shiftValid(shiftValid), .reEncStb(reEncStb), .berStb(berStb), .done(done)
);

// File: tb/viterbi_flush_seq_test.sv
`timescale 1ns/1ps
module viterbi_flush_seq_test;
  localparam int NS = 8, MW = 8, CW = 8, DEPTH = 6, SW = 3;

  logic clk = 0, rstN = 0;
  logic start = 0, decEn = 0, eqEn = 0, flushEn = 0, flushPolicy = 0, symValid = 0;
  logic [SW-1:0] endState = '0;
  logic [CW-1:0] blockLen = '0;
  logic [SW-1:0] metricAddr, tbState;
  logic [MW-1:0] metricData;
  logic [MW-1:0] mem [NS];
  logic symReady, shiftValid, reEncStb, berStb, done;
  logic [1:0] mode;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;
  assign metricData = mem[metricAddr];

  viterbi_flush_seq uut (
    .clk(clk), .rstN(rstN), .start(start), .decEn(decEn), .eqEn(eqEn),
    .flushEn(flushEn), .flushPolicy(flushPolicy), .endState(endState),
    .blockLen(blockLen), .symValid(symValid), .symReady(symReady),
    .metricAddr(metricAddr), .metricData(metricData), .mode(mode),
    .tbState(tbState), .shiftValid(shiftValid), .reEncStb(reEncStb),
    .berStb(berStb), .done(done)
  );

  // behavioural reference: 0 idle, 1 active, 2 scan, 3 shift
  int ms = 0, mCnt = 0, mLeft = 0, mIdx = 0, mBest = 0, mBestIdx = 0, mTb = 0;
  bit mBer = 0, mDone = 0;

  function automatic bit mForce();
    return flushEn && !decEn && !eqEn;
  endfunction
  function automatic bit mReady();
    return (ms == 1) && !mForce();
  endfunction
  function automatic bit mReEnc();
    return (mReady() && symValid) || (ms == 3);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      ms = 0; mCnt = 0; mLeft = 0; mIdx = 0; mTb = 0; mBer = 0; mDone = 0;
    end else begin
      bit acc, flush;
      mBer = mReEnc();
      acc = mReady() && symValid;
      mDone = 0;
      case (ms)
        0: if (start && (decEn != eqEn)) begin ms = 1; mCnt = blockLen; end
        1: begin
          flush = mForce() || mCnt == 0 || (acc && mCnt == 1);
          if (acc) mCnt--;
          if (flush) begin
            if (flushPolicy) begin ms = 2; mIdx = 0; end
            else begin ms = 3; mTb = endState; mLeft = DEPTH; end
          end
        end
        2: begin
          if (mIdx == 0 || mem[mIdx] < mBest) begin mBest = mem[mIdx]; mBestIdx = mIdx; end
          if (mIdx == NS - 1) begin ms = 3; mTb = mBestIdx; mLeft = DEPTH; end
          mIdx++;
        end
        default: begin
          mLeft--;
          if (mLeft == 0) begin ms = 0; mDone = 1; end
        end
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // compare every cycle away from the edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2/R4/R10 mode", mode, (ms == 0) ? 0 : (ms == 1) ? 1 : 2);
      chk("R3/R5 symReady", symReady, mReady());
      chk("R8 shiftValid", shiftValid, ms == 3);
      chk("R9 reEncStb", reEncStb, mReEnc());
      chk("R9 berStb", berStb, mBer);
      chk("R10 done", done, mDone);
      if (ms == 2) chk("R7 metricAddr", metricAddr, mIdx);
      if (ms == 3) chk("R6/R7/R8 tbState", tbState, mTb);
    end
  end

  always @(posedge clk) if (cyc > 20000) begin
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic begin_block(bit d, bit e, int len, bit pol, int es);
    decEn = d; eqEn = e; blockLen = CW'(len); flushPolicy = pol;
    endState = SW'(es); start = 1;
    step(1);
    start = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (mode != 2'd0 && guard < 200) begin step(1); guard++; end
    step(2);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) mem[i] = MW'(50 + i);
    step(3);
    // R1 reset state
    chk("R1 mode", mode, 0); chk("R1 symReady", symReady, 0);
    chk("R1 shiftValid", shiftValid, 0); chk("R1 reEncStb", reEncStb, 0);
    chk("R1 berStb", berStb, 0); chk("R1 done", done, 0);
    rstN = 1;
    step(2);

    // R2 R4 R6: decode block, gapped symbols, end-state policy
    begin_block(1, 0, 4, 0, 5);
    for (int i = 0; i < 8; i++) begin symValid = i[0]; step(1); end
    symValid = 0;
    wait_idle();

    // R7 tie at indices 1 and 3, equalize mode
    mem[0] = 40; mem[1] = 12; mem[2] = 30; mem[3] = 12;
    mem[4] = 99; mem[5] = 13; mem[6] = 20; mem[7] = 25;
    begin_block(0, 1, 3, 1, 0);
    symValid = 1; step(3); symValid = 0;
    wait_idle();
    chk("R7 tie picks lower index", tbState, 1);

    // R7 minimum at last state
    mem[7] = 2;
    begin_block(1, 0, 2, 1, 0);
    symValid = 1; step(2); symValid = 0;
    wait_idle();
    chk("R7 last index wins", tbState, 7);

    // R5 forced flush together with a valid symbol
    begin_block(1, 0, 20, 0, 3);
    symValid = 1; step(3);
    decEn = 0; flushEn = 1;
    step(1);
    flushEn = 0; symValid = 0;
    wait_idle();
    chk("R5 forced flush end state", tbState, 3);

    // R11 invalid double enable
    begin_block(1, 1, 4, 0, 2);
    step(2);
    chk("R11 stays idle", mode, 0);

    // R4 zero-length block
    begin_block(0, 1, 0, 0, 6);
    wait_idle();
    chk("R4 zero length flush state", tbState, 6);

    step(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule